// File: doc/BRIEF.md
# NAND Page Program Command Sequencer

This block sits on the host side of a raw NAND flash interface and turns one program request into an ordered stream of bus cycles on an 8-bit multiplexed bus. A single-cycle start pulse latches the mode flags, the confirm flags, the block, page and column address and the byte count. The block then emits a command cycle carrying the opening opcode, a run of address cycles, a programmable settling interval, the data cycles and, when asked, a confirm command. Each cycle is tagged as command, address or data. A timing back end takes the cycle and drives the pins, and data bytes are pulled one at a time from a data-source port.

Four program flavours are supported: ordinary, one-time-programmable area, internal data move and copy-back. A random data input operation, which changes the column inside a page that is already open, shares the same machinery. It can also be limited to a column-only address phase. Leaving the finalize flag clear ends the stream without a confirm opcode, so that a later random data input can keep filling the same page.

The state machine has six states. In ST_IDLE a start pulse moves to ST_CMD. In ST_CMD an accepted cycle moves to ST_ADDR. In ST_ADDR the last accepted address goes to ST_WAIT, or, when the interval is zero, straight to the post-wait target. In ST_WAIT the expired interval goes to the post-wait target. That target is ST_DATA when data is due, otherwise ST_CONF when finalize is set, otherwise ST_IDLE. In ST_DATA the last accepted byte goes to ST_CONF or ST_IDLE. In ST_CONF an accepted cycle returns to ST_IDLE.

Top module: `nand_prog_seq`

## Requirements
- R1: The opening command byte is A0h when the OTP flag is set, else 85h when the move flag is set, else 8Ch when the copy-back flag is set, else 80h. It is the first cycle of every sequence and is tagged command (cyc_kind 2'b01).
- R2: Address cycles (cyc_kind 2'b10) carry, in this order: column bits 7:0, then column bits from 8 upward zero-extended to a byte, then the row bytes least significant first. The row is {blk_addr, page_addr}, with the page in the low PAGE_W bits, zero-extended to 24 bits.
- R3: In OTP mode the second and third row bytes are sent as 00h, and the first row byte is sent unchanged.
- R4: After the last address cycle is accepted, cyc_valid stays low for exactly tadl_cycles clock cycles before the next cycle is presented. A value of 0 means the next cycle is presented in the following clock cycle.
- R5: No data cycle is issued when byte_cnt is zero, or when the move flag is set while both the OTP flag and the random flag are clear.
- R6: With finalize set, the last cycle is a command (2'b01) of 11h when two_plane is set, else 15h when cache_prog is set, else 10h.
- R7: With finalize clear, no confirm cycle is issued, and busy falls once the last address or data cycle is done.
- R8: With mode_rand set, the opening opcode is 85h whatever the other mode flags are, the row bytes are never zeroed, and rand_col_only limits the address phase to the two column cycles.
- R9: busy is low after reset and rises in the cycle after an accepted start. A start pulse while busy is ignored. cyc_valid is never high while busy is low.
- R10: A presented cycle keeps cyc_valid, cyc_kind and cyc_byte unchanged until cyc_accept is seen high.
- R11: Data cycles (cyc_kind 2'b11) carry src_data. src_pop pulses once for each accepted data cycle, byte_cnt times in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode_otp | input | 1 | Program into the one-time-programmable area |
| mode_move | input | 1 | Internal data move program |
| mode_copyback | input | 1 | Copy-back program |
| mode_rand | input | 1 | Random data input within an open page |
| rand_col_only | input | 1 | Random data input sends only the column cycles |
| finalize | input | 1 | Issue a confirm opcode at the end |
| cache_prog | input | 1 | Confirm as a cache program |
| two_plane | input | 1 | Confirm as the first plane of a two-plane program |
| blk_addr | input | BLK_W | Block address |
| page_addr | input | PAGE_W | Page within the block |
| col_addr | input | COL_W | Starting column |
| byte_cnt | input | CNT_W | Number of data bytes |
| tadl_cycles | input | TADL_W | Address-to-data settling interval in clocks |
| busy | output | 1 | Sequence in progress |
| cyc_valid | output | 1 | A bus cycle is presented |
| cyc_kind | output | 2 | 01 command, 10 address, 11 data, 00 none |
| cyc_byte | output | 8 | Byte of the presented cycle |
| cyc_accept | input | 1 | Back end takes the presented cycle |
| src_data | input | 8 | Next data byte from the source |
| src_pop | output | 1 | Current data byte consumed |

## Verification
Two functions can coincide in the same cycle: the acceptance of the last address cycle and the end of the settling interval. With tadl_cycles at zero, the cycle after the last address is accepted must already present data or the confirm. The bench provokes this with a column-only random data input at a zero interval while the back end stalls in a rotating pattern. It judges the result through the scoreboard's gap count: the number of idle bus cycles seen before each item must match the interval the requirements give, which is zero here and the programmed value elsewhere.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_CONF
    } nps_state_e;

    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_CMD  = 2'b01,
        CYC_ADDR = 2'b10,
        CYC_DATA = 2'b11
    } nps_kind_e;

    localparam logic [7:0] OP_PROG      = 8'h80;
    localparam logic [7:0] OP_OTP       = 8'hA0;
    localparam logic [7:0] OP_MOVE      = 8'h85;
    localparam logic [7:0] OP_COPYBACK  = 8'h8C;
    localparam logic [7:0] OP_CONF      = 8'h10;
    localparam logic [7:0] OP_CONF_TP   = 8'h11;
    localparam logic [7:0] OP_CONF_CACHE = 8'h15;

    // Flags latched for one sequence
    typedef struct packed {
        logic otp;
        logic move;
        logic copyback;
        logic rnd;
        logic col_only;
        logic fin;
        logic cache;
        logic tp;
    } nps_job_t;

endpackage

// File: rtl/nps_opsel.sv
module nps_opsel
    import nps_pkg::*;
(
    input  nps_job_t   job,
    output logic [7:0] open_op,
    output logic [7:0] conf_op
);

    always_comb begin
        if (job.rnd)
            open_op = OP_MOVE;
        else if (job.otp)
            open_op = OP_OTP;
        else if (job.move)
            open_op = OP_MOVE;
        else if (job.copyback)
            open_op = OP_COPYBACK;
        else
            open_op = OP_PROG;
    end

    always_comb begin
        if (job.tp)
            conf_op = OP_CONF_TP;
        else if (job.cache)
            conf_op = OP_CONF_CACHE;
        else
            conf_op = OP_CONF;
    end

endmodule

// File: rtl/nps_addr.sv
module nps_addr #(
    parameter int COL_W = 12,
    parameter int ROW_W = 17
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic             zero_hi_row,
    input  logic [2:0]       idx,
    output logic [7:0]       addr_byte
);

    localparam int NSLOT    = 5;
    localparam int NROWB    = 3;
    localparam int COLHI_SH = 8;

    logic [23:0]      row24;
    logic [COL_W-1:0] col_hi;
    logic [7:0]       slot [NSLOT];

    assign row24  = 24'(row);
    assign col_hi = col >> COLHI_SH;

    assign slot[0] = col[7:0];
    assign slot[1] = col_hi[7:0];

    for (genvar k = 0; k < NROWB; k++) begin : g_row
        if (k == 0) begin : g_keep
            assign slot[2+k] = row24[8*k +: 8];
        end else begin : g_clear
            assign slot[2+k] = zero_hi_row ? 8'h00 : row24[8*k +: 8];
        end
    end

    always_comb begin
        addr_byte = 8'h00;
        for (int s = 0; s < NSLOT; s++) begin
            if (idx == 3'(s))
                addr_byte = slot[s];
        end
    end

endmodule

// File: rtl/nps_tadl.sv
module nps_tadl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
    import nps_pkg::*;
#(
    parameter int BLK_W  = 11,
    parameter int PAGE_W = 6,
    parameter int COL_W  = 12,
    parameter int CNT_W  = 13,
    parameter int TADL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_otp,
    input  logic              mode_move,
    input  logic              mode_copyback,
    input  logic              mode_rand,
    input  logic              rand_col_only,
    input  logic              finalize,
    input  logic              cache_prog,
    input  logic              two_plane,
    input  logic [BLK_W-1:0]  blk_addr,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [COL_W-1:0]  col_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [TADL_W-1:0] tadl_cycles,
    output logic              busy,
    output logic              cyc_valid,
    output logic [1:0]        cyc_kind,
    output logic [7:0]        cyc_byte,
    input  logic              cyc_accept,
    input  logic [7:0]        src_data,
    output logic              src_pop
);

    localparam int ROW_W      = BLK_W + PAGE_W;
    localparam int ADDR_FULL  = 5;
    localparam int ADDR_SHORT = 2;

    nps_state_e        st, st_nx;
    nps_job_t          job;
    logic [COL_W-1:0]  j_col;
    logic [ROW_W-1:0]  j_row;
    logic [CNT_W-1:0]  rem;
    logic [TADL_W-1:0] j_tadl;
    logic              j_data;
    logic [2:0]        aidx;

    logic [7:0] open_op, conf_op, addr_byte;
    logic       acc, last_addr, wait_done, tadl_load;
    nps_state_e post_wait;

    nps_opsel u_opsel (
        .job     (job),
        .open_op (open_op),
        .conf_op (conf_op)
    );

    nps_addr #(.COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .col         (j_col),
        .row         (j_row),
        .zero_hi_row (job.otp && !job.rnd),
        .idx         (aidx),
        .addr_byte   (addr_byte)
    );

    nps_tadl #(.W(TADL_W)) u_tadl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tadl_load),
        .load_val (TADL_W'(j_tadl - 1'b1)),
        .run      (st == ST_WAIT),
        .done     (wait_done)
    );

    assign acc       = cyc_valid && cyc_accept;
    assign last_addr = (job.rnd && job.col_only) ? (aidx == 3'(ADDR_SHORT - 1))
                                                 : (aidx == 3'(ADDR_FULL - 1));
    assign tadl_load = (st == ST_ADDR) && acc && last_addr && (j_tadl != '0);

    always_comb begin
        if (j_data)
            post_wait = ST_DATA;
        else if (job.fin)
            post_wait = ST_CONF;
        else
            post_wait = ST_IDLE;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_CMD;
            ST_CMD:  if (acc) st_nx = ST_ADDR;
            ST_ADDR: if (acc && last_addr)
                         st_nx = (j_tadl == '0) ? post_wait : ST_WAIT;
            ST_WAIT: if (wait_done) st_nx = post_wait;
            ST_DATA: if (acc && rem == CNT_W'(1))
                         st_nx = job.fin ? ST_CONF : ST_IDLE;
            ST_CONF: if (acc) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register and sequence context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            job    <= '0;
            j_col  <= '0;
            j_row  <= '0;
            rem    <= '0;
            j_tadl <= '0;
            j_data <= 1'b0;
            aidx   <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && start) begin
                job.otp      <= mode_otp;
                job.move     <= mode_move;
                job.copyback <= mode_copyback;
                job.rnd      <= mode_rand;
                job.col_only <= rand_col_only;
                job.fin      <= finalize;
                job.cache    <= cache_prog;
                job.tp       <= two_plane;
                j_col        <= col_addr;
                j_row        <= {blk_addr, page_addr};
                rem          <= byte_cnt;
                j_tadl       <= tadl_cycles;
                j_data       <= (byte_cnt != '0) &&
                                !(mode_move && !mode_otp && !mode_rand);
                aidx         <= '0;
            end
            if (st == ST_ADDR && acc)
                aidx <= aidx + 3'd1;
            if (st == ST_DATA && acc)
                rem <= rem - 1'b1;
        end
    end

    // Output logic
    always_comb begin
        cyc_valid = 1'b0;
        cyc_kind  = CYC_NONE;
        cyc_byte  = 8'h00;
        src_pop   = 1'b0;
        unique case (st)
            ST_IDLE, ST_WAIT: ;
            ST_CMD: begin
                cyc_valid = 1'b1;
                cyc_kind  = CYC_CMD;
                cyc_byte  = open_op;
            end
            ST_ADDR: begin
                cyc_valid = 1'b1;
                cyc_kind  = CYC_ADDR;
                cyc_byte  = addr_byte;
            end
            ST_DATA: begin
                cyc_valid = 1'b1;
                cyc_kind  = CYC_DATA;
                cyc_byte  = src_data;
                src_pop   = cyc_accept;
            end
            ST_CONF: begin
                cyc_valid = 1'b1;
                cyc_kind  = CYC_CMD;
                cyc_byte  = conf_op;
            end
            default: ;
        endcase
    end

    assign busy = (st != ST_IDLE);

    // R10
    hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_accept) |=> (cyc_valid && $stable(cyc_kind) && $stable(cyc_byte)));

    // R9
    idle_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cyc_valid);

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R1
    opens_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cyc_valid && cyc_kind == CYC_CMD));

    // R11
    pop_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (cyc_valid && cyc_accept && cyc_kind == CYC_DATA));

endmodule

// File: tb/test_nand_prog_seq.sv
`timescale 1ns/1ps
module test_nand_prog_seq;

    localparam int BLK_W  = 11;
    localparam int PAGE_W = 6;
    localparam int COL_W  = 12;
    localparam int CNT_W  = 13;
    localparam int TADL_W = 8;

    typedef struct {
        logic [1:0] kind;
        logic [7:0] val;
        int         gap;
        string      req;
    } exp_t;

    exp_t sbq[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode_otp = 0, mode_move = 0, mode_copyback = 0, mode_rand = 0;
    logic rand_col_only = 0, finalize = 0, cache_prog = 0, two_plane = 0;
    logic [BLK_W-1:0]  blk_addr = '0;
    logic [PAGE_W-1:0] page_addr = '0;
    logic [COL_W-1:0]  col_addr = '0;
    logic [CNT_W-1:0]  byte_cnt = '0;
    logic [TADL_W-1:0] tadl_cycles = '0;
    logic busy, cyc_valid, cyc_accept, src_pop;
    logic [1:0] cyc_kind;
    logic [7:0] cyc_byte, src_data;

    logic       stall_en = 1'b0;
    logic [7:0] acc_sr = 8'b1101_0110;
    logic [7:0] src_base = 8'h00;
    logic [7:0] src_off = 8'h00;

    int n_chk = 0, n_fail = 0, cyc_n = 0, gapc = 0;
    logic       p_hold = 1'b0;
    logic [1:0] p_kind = '0;
    logic [7:0] p_byte = '0;

    always #4 clk = ~clk;

    assign cyc_accept = stall_en ? acc_sr[0] : 1'b1;
    assign src_data   = src_base + src_off;

    always @(posedge clk) begin
        acc_sr <= {acc_sr[0], acc_sr[7:1]};
        if (start && !busy) src_off <= 8'h00;
        else if (src_pop)   src_off <= src_off + 8'h01;
    end

    nand_prog_seq #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
                    .CNT_W(CNT_W), .TADL_W(TADL_W)) i_nand_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mode_otp(mode_otp), .mode_move(mode_move), .mode_copyback(mode_copyback),
        .mode_rand(mode_rand), .rand_col_only(rand_col_only), .finalize(finalize),
        .cache_prog(cache_prog), .two_plane(two_plane),
        .blk_addr(blk_addr), .page_addr(page_addr), .col_addr(col_addr),
        .byte_cnt(byte_cnt), .tadl_cycles(tadl_cycles),
        .busy(busy), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
        .cyc_accept(cyc_accept), .src_data(src_data), .src_pop(src_pop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] v, input int g, input string r);
        exp_t e;
        e.kind = k; e.val = v; e.gap = g; e.req = r;
        sbq.push_back(e);
    endtask

    // Monitor: compares accepted cycles against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_hold)
                chk(cyc_valid && cyc_kind == p_kind && cyc_byte == p_byte,
                    "R10 hold", {cyc_valid, cyc_kind, cyc_byte}, {1'b1, p_kind, p_byte});
            if (cyc_valid && cyc_accept) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R7 unexpected cycle", {cyc_kind, cyc_byte}, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(cyc_kind == e.kind && cyc_byte == e.val, e.req,
                        {cyc_kind, cyc_byte}, {e.kind, e.val});
                    if (e.gap >= 0)
                        chk(gapc == e.gap, "R4 gap", gapc, e.gap);
                end
                gapc = 0;
            end else if (busy && !cyc_valid) begin
                gapc++;
            end
            p_hold = cyc_valid && !cyc_accept;
            p_kind = cyc_kind;
            p_byte = cyc_byte;
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d cycles expected < 150000", cyc_n);
            report();
            $finish;
        end
    end

    task automatic run_op(input bit otp, input bit mv, input bit cb, input bit rnd,
                          input bit conly, input bit fin, input bit cch, input bit tp,
                          input int blk, input int pg, input int col, input int cnt,
                          input int tadl, input logic [7:0] base, input bit junk);
        int row, lastgap;
        bool_dummy: begin end
        row = (blk << PAGE_W) | pg;
        // R1 / R8: opening opcode
        if (rnd)      push(2'b01, 8'h85, -1, "R8 open");
        else if (otp) push(2'b01, 8'hA0, -1, "R1 open");
        else if (mv)  push(2'b01, 8'h85, -1, "R1 open");
        else if (cb)  push(2'b01, 8'h8C, -1, "R1 open");
        else          push(2'b01, 8'h80, -1, "R1 open");
        // R2: column then row bytes
        push(2'b10, 8'(col), 0, "R2 col lo");
        push(2'b10, 8'(col >> 8), 0, "R2 col hi");
        if (!(rnd && conly)) begin
            push(2'b10, 8'(row), 0, "R2 row0");
            push(2'b10, (otp && !rnd) ? 8'h00 : 8'(row >> 8), 0, "R3 row1");
            push(2'b10, (otp && !rnd) ? 8'h00 : 8'(row >> 16), 0, "R3 row2");
        end
        lastgap = tadl;
        // R5 / R11: data bytes
        if (cnt != 0 && !(mv && !otp && !rnd)) begin
            for (int i = 0; i < cnt; i++) begin
                push(2'b11, base + 8'(i), (i == 0) ? lastgap : 0, "R11 data");
            end
            lastgap = 0;
        end
        // R6: confirm
        if (fin)
            push(2'b01, tp ? 8'h11 : (cch ? 8'h15 : 8'h10), lastgap, "R6 confirm");

        @(negedge clk);
        mode_otp = otp; mode_move = mv; mode_copyback = cb; mode_rand = rnd;
        rand_col_only = conly; finalize = fin; cache_prog = cch; two_plane = tp;
        blk_addr = BLK_W'(blk); page_addr = PAGE_W'(pg); col_addr = COL_W'(col);
        byte_cnt = CNT_W'(cnt); tadl_cycles = TADL_W'(tadl); src_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy rise", busy, 1);
        if (junk) begin
            // R9: a start while busy must not alter the running sequence
            mode_otp = 1'b1; mode_rand = 1'b1; col_addr = '1; byte_cnt = 7;
            finalize = ~fin; src_base = base;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(sbq.size() == 0, "R7 sequence length", sbq.size(), 0);
        chk(cyc_valid == 1'b0, "R9 idle quiet", cyc_valid, 0);
        sbq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0 && cyc_valid == 1'b0 && src_pop == 1'b0, "R9 reset",
            {busy, cyc_valid, src_pop}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        stall_en = 1'b1;
        // normal program, confirm 10h
        run_op(0,0,0,0, 0,1,0,0, 11'h5A3, 6'h2B, 12'hA7C, 4, 3, 8'h40, 0);
        // OTP: high row bytes zeroed (R3)
        run_op(1,0,0,0, 0,1,0,0, 11'h7FF, 6'h3F, 12'h123, 2, 2, 8'hF0, 0);
        // internal move: no data (R5), two-plane confirm
        run_op(0,1,0,0, 0,1,0,1, 11'h011, 6'h05, 12'h800, 5, 4, 8'h00, 0);
        // copy-back with cache confirm
        run_op(0,0,1,0, 0,1,1,0, 11'h2C4, 6'h11, 12'hFFF, 3, 1, 8'hFE, 0);
        // zero count, no finalize (R5, R7)
        run_op(0,0,0,0, 0,0,0,0, 11'h001, 6'h01, 12'h0FF, 0, 2, 8'h00, 0);
        // random input, column only, zero interval (R8, R4)
        run_op(1,0,0,1, 1,0,0,0, 11'h3AA, 6'h15, 12'h9B1, 3, 0, 8'h77, 0);
        // random input, full address, two-plane confirm (R8)
        run_op(1,1,1,1, 0,1,1,1, 11'h155, 6'h2A, 12'h304, 2, 5, 8'h10, 0);
        // start while busy ignored (R9), no stalls
        stall_en = 1'b0;
        run_op(0,0,0,0, 0,1,1,0, 11'h0F0, 6'h0F, 12'h010, 3, 0, 8'h90, 1);
        // finalize clear after data (R7)
        run_op(0,0,0,0, 0,0,0,0, 11'h222, 6'h22, 12'h222, 2, 1, 8'h33, 0);

        report();
        $finish;
    end

endmodule